// File: doc/BRIEF.md
# Display Power-Up and Identification Sequencer

This block brings up a display path built from a bridge controller and a panel. On a power-up request it releases the controller from power-down, reads two controller registers over a parallel read port, and classifies the controller version. It then takes the panel out of reset and reads three identity bytes over a 9-bit serial command port. If both identities are known, it runs the panel wake program and reports the display as active.

A power-down request on an active display sends display-off and sleep-in, waits for the sleep settle time, and then puts the controller back into power-down. Panel reset is never lowered again once it has been raised. An unknown controller or panel code ends power-up with an error code, and the controller goes back into power-down. Both bus engines are outside the block. Each is driven by a one-cycle request strobe and answers with a one-cycle done pulse, which comes at least one cycle after the strobe. Delays are counted in milliseconds from a prescaled tick, and the clock rate is set by a parameter.

Top module: `disp_bringup_seq`

## Requirements
- R1: After reset, ctrl_pwr_o, panel_rst_o and active_o are low, err_o is 0 and no request strobe is raised.
- R2: An accepted power-up request sets ctrl_pwr_o on the following clock edge. The block then issues two parallel reads, address 0x00 (revision) followed by address 0x02 (straps). Each read is one request strobe, and the block waits for its done pulse.
- R3: The revision byte is masked with 0xFC. Masked 0xA4 gives ver_o=1 and masked 0x9C gives ver_o=2. step_o is revision bits [1:0] and strap_o is the strap byte bits [2:0].
- R4: Any other masked revision sets err_o=1, lowers ctrl_pwr_o and leaves panel_rst_o unchanged. No serial transfer follows.
- R5: A known controller raises panel_rst_o. The serial port then sends command word 0x004 followed by three read transfers (scmd_rd_o=1). A first byte of 0x45 gives panel_o=1 and 0x83 gives panel_o=2. panel_rev_o takes the second byte.
- R6: Any other first identity byte sets err_o=2 and lowers ctrl_pwr_o, while panel_rst_o stays high.
- R7: Serial word bit 8 is 1 for data and 0 for commands. The wake program sends 0x011, waits, then sends 0x0C2, 0x102, 0x100, 0x100, 0x03A, 0x170 and 0x029, in that order.
- R8: Between the done of word 0x011 and the strobe of word 0x0C2 there are at least WAKE_MS*CLK_KHZ cycles and at most 6 more.
- R9: active_o stays low until word 0x029 completes and rises within 3 cycles after that.
- R10: A power-down request while active clears active_o on the next edge and sends 0x028 then 0x010. After the done of 0x010, ctrl_pwr_o falls between SLEEP_MS*CLK_KHZ and SLEEP_MS*CLK_KHZ+6 cycles later. panel_rst_o stays high.
- R11: The block ignores a power-up request while active, a power-down request while off, and any request while a sequence is running. Ignoring means no bus traffic and no output change.
- R12: err_o holds its value until the next accepted power-up, which clears it.
- R13: Request strobes last one cycle, and the two ports are never strobed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_up_i | input | 1 | Power-up request |
| pwr_dn_i | input | 1 | Power-down request |
| pbus_req_o | output | 1 | Parallel read strobe |
| pbus_addr_o | output | 8 | Parallel read address |
| pbus_done_i | input | 1 | Parallel read complete |
| pbus_rdata_i | input | 8 | Parallel read data |
| scmd_req_o | output | 1 | Serial transfer strobe |
| scmd_rd_o | output | 1 | Serial transfer is a byte read |
| scmd_word_o | output | 9 | Serial word, bit 8 set for data |
| scmd_done_i | input | 1 | Serial transfer complete |
| scmd_rdata_i | input | 8 | Serial read byte |
| ctrl_pwr_o | output | 1 | Controller power-down line (high = running) |
| panel_rst_o | output | 1 | Panel reset line (high = released) |
| active_o | output | 1 | Display brought up |
| ver_o | output | 2 | Controller version, 0 = none |
| step_o | output | 2 | Controller stepping |
| strap_o | output | 3 | Controller strap bits |
| panel_o | output | 2 | Panel type, 0 = none |
| panel_rev_o | output | 8 | Panel revision byte |
| err_o | output | 2 | 0 none, 1 bad controller, 2 bad panel |

## Verification
The bench builds the block with CLK_KHZ=10 and keeps WAKE_MS=120 and SLEEP_MS=50. This shrinks the wake wait to 1200 cycles and the sleep wait to 500 cycles. With those values both full waits, the exact wait bounds and back-to-back bring-ups fit in a short run. It does not need a scaled-down millisecond count.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;
  typedef enum logic [1:0] {ERR_NONE = 2'd0, ERR_CTRL = 2'd1, ERR_PANEL = 2'd2} err_e;
  typedef enum logic [1:0] {OP_SEND, OP_WAIT_WAKE, OP_WAIT_SLEEP, OP_END} op_e;
  typedef enum logic [2:0] {
    ST_OFF, ST_RD_REV, ST_RD_CFG, ST_ID_CMD, ST_ID_RD, ST_PROG, ST_WAIT, ST_ON
  } state_e;

  typedef struct packed {
    op_e        op;
    logic [8:0] word;
  } step_t;

  localparam int unsigned PROG_W = 4;
  localparam logic [PROG_W-1:0] PROG_UP = 4'd0;
  localparam logic [PROG_W-1:0] PROG_DN = 4'd10;

  localparam logic [7:0] ADDR_REV  = 8'h00;
  localparam logic [7:0] ADDR_CFG  = 8'h02;
  localparam logic [8:0] W_READ_ID = 9'h004;

  localparam logic [7:0] REV_MASK = 8'hFC;
  localparam logic [7:0] REV_V1   = 8'hA4;
  localparam logic [7:0] REV_V2   = 8'h9C;
  localparam logic [7:0] PANEL_A  = 8'h45;
  localparam logic [7:0] PANEL_B  = 8'h83;
endpackage

// File: rtl/disp_seq_rom.sv
module disp_seq_rom
  import disp_seq_pkg::*;
(
  input  logic [PROG_W-1:0] idx_i,
  output step_t             step_o
);
  // wake program at PROG_UP, sleep program at PROG_DN
  always_comb begin
    step_o.op   = OP_SEND;
    step_o.word = 9'h000;
    case (idx_i)
      4'd0:  step_o.word = 9'h011;
      4'd1:  step_o.op   = OP_WAIT_WAKE;
      4'd2:  step_o.word = 9'h0C2;
      4'd3:  step_o.word = 9'h102;
      4'd4:  step_o.word = 9'h100;
      4'd5:  step_o.word = 9'h100;
      4'd6:  step_o.word = 9'h03A;
      4'd7:  step_o.word = 9'h170;
      4'd8:  step_o.word = 9'h029;
      4'd10: step_o.word = 9'h028;
      4'd11: step_o.word = 9'h010;
      4'd12: step_o.op   = OP_WAIT_SLEEP;
      default: step_o.op = OP_END;
    endcase
  end
endmodule

// File: rtl/disp_id_classify.sv
module disp_id_classify
  import disp_seq_pkg::*;
(
  input  logic [7:0] rev_i,
  input  logic [7:0] id0_i,
  output logic [1:0] ver_o,
  output logic [1:0] panel_o
);
  logic [7:0] rev_m;
  assign rev_m = rev_i & REV_MASK;

  always_comb begin
    if (rev_m == REV_V1)      ver_o = 2'd1;
    else if (rev_m == REV_V2) ver_o = 2'd2;
    else                      ver_o = 2'd0;
  end

  always_comb begin
    if (id0_i == PANEL_A)      panel_o = 2'd1;
    else if (id0_i == PANEL_B) panel_o = 2'd2;
    else                       panel_o = 2'd0;
  end
endmodule

// File: rtl/disp_ms_timer.sv
module disp_ms_timer #(
  parameter int unsigned TICKS_PER_MS = 100000,
  parameter int unsigned MS_W         = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [MS_W-1:0] ms_i,
  output logic            done_o
);
  localparam int unsigned PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

  logic [PRE_W-1:0] pre_q;
  logic [MS_W-1:0]  ms_q;
  logic             run_q;

  assign done_o = run_q && (ms_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ms_q  <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      pre_q <= '0;
      ms_q  <= ms_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (ms_q == '0) begin
        run_q <= 1'b0;
      end else if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        ms_q  <= ms_q - MS_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/disp_bringup_seq.sv
module disp_bringup_seq
  import disp_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 100000,
  parameter int unsigned WAKE_MS  = 120,
  parameter int unsigned SLEEP_MS = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_up_i,
  input  logic       pwr_dn_i,
  output logic       pbus_req_o,
  output logic [7:0] pbus_addr_o,
  input  logic       pbus_done_i,
  input  logic [7:0] pbus_rdata_i,
  output logic       scmd_req_o,
  output logic       scmd_rd_o,
  output logic [8:0] scmd_word_o,
  input  logic       scmd_done_i,
  input  logic [7:0] scmd_rdata_i,
  output logic       ctrl_pwr_o,
  output logic       panel_rst_o,
  output logic       active_o,
  output logic [1:0] ver_o,
  output logic [1:0] step_o,
  output logic [2:0] strap_o,
  output logic [1:0] panel_o,
  output logic [7:0] panel_rev_o,
  output logic [1:0] err_o
);
  localparam int unsigned MS_MAX = (WAKE_MS > SLEEP_MS) ? WAKE_MS : SLEEP_MS;
  localparam int unsigned MS_W   = $clog2(MS_MAX + 1);

  state_e           st_q;
  logic [PROG_W-1:0] idx_q;
  logic [1:0]       rd_cnt_q;
  logic             wait_q;
  logic             ctrl_pwr_q, panel_rst_q, active_q;
  logic [7:0]       rev_q, id0_q, id1_q, panel_rev_q;
  logic [1:0]       ver_q, step_q, panel_q;
  logic [2:0]       strap_q;
  err_e             err_q;

  step_t            step;
  logic [1:0]       ver_dec, panel_dec;
  logic             p_cyc, s_cyc, p_done, s_done;
  logic             t_start, t_done;
  logic [MS_W-1:0]  t_ms;

  disp_seq_rom u_rom (
    .idx_i  (idx_q),
    .step_o (step)
  );

  disp_id_classify u_cls (
    .rev_i   (rev_q),
    .id0_i   (id0_q),
    .ver_o   (ver_dec),
    .panel_o (panel_dec)
  );

  disp_ms_timer #(
    .TICKS_PER_MS (CLK_KHZ),
    .MS_W         (MS_W)
  ) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (t_start),
    .ms_i    (t_ms),
    .done_o  (t_done)
  );

  assign p_cyc  = (st_q == ST_RD_REV) || (st_q == ST_RD_CFG);
  assign s_cyc  = (st_q == ST_ID_CMD) || (st_q == ST_ID_RD) ||
                  ((st_q == ST_PROG) && (step.op == OP_SEND));
  assign p_done = p_cyc && wait_q && pbus_done_i;
  assign s_done = s_cyc && wait_q && scmd_done_i;

  assign pbus_req_o  = p_cyc && !wait_q;
  assign pbus_addr_o = (st_q == ST_RD_CFG) ? ADDR_CFG : ADDR_REV;
  assign scmd_req_o  = s_cyc && !wait_q;
  assign scmd_rd_o   = (st_q == ST_ID_RD);
  assign scmd_word_o = (st_q == ST_ID_CMD) ? W_READ_ID :
                       (st_q == ST_PROG)   ? step.word : 9'h000;

  assign t_start = (st_q == ST_PROG) &&
                   ((step.op == OP_WAIT_WAKE) || (step.op == OP_WAIT_SLEEP));
  assign t_ms    = (step.op == OP_WAIT_WAKE) ? MS_W'(WAKE_MS) : MS_W'(SLEEP_MS);

  // one outstanding transfer across both ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       wait_q <= 1'b0;
    else if (pbus_req_o || scmd_req_o) wait_q <= 1'b1;
    else if (p_done || s_done)         wait_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_OFF;
      idx_q       <= PROG_UP;
      rd_cnt_q    <= 2'd0;
      ctrl_pwr_q  <= 1'b0;
      panel_rst_q <= 1'b0;
      active_q    <= 1'b0;
      rev_q       <= 8'h00;
      id0_q       <= 8'h00;
      id1_q       <= 8'h00;
      panel_rev_q <= 8'h00;
      ver_q       <= 2'd0;
      step_q      <= 2'd0;
      panel_q     <= 2'd0;
      strap_q     <= 3'd0;
      err_q       <= ERR_NONE;
    end else begin
      case (st_q)
        ST_OFF: if (pwr_up_i) begin
          ctrl_pwr_q  <= 1'b1;
          err_q       <= ERR_NONE;
          ver_q       <= 2'd0;
          step_q      <= 2'd0;
          strap_q     <= 3'd0;
          panel_q     <= 2'd0;
          panel_rev_q <= 8'h00;
          st_q        <= ST_RD_REV;
        end
        ST_RD_REV: if (p_done) begin
          rev_q <= pbus_rdata_i;
          st_q  <= ST_RD_CFG;
        end
        ST_RD_CFG: if (p_done) begin
          if (ver_dec == 2'd0) begin
            err_q      <= ERR_CTRL;
            ctrl_pwr_q <= 1'b0;
            st_q       <= ST_OFF;
          end else begin
            ver_q       <= ver_dec;
            step_q      <= rev_q[1:0];
            strap_q     <= pbus_rdata_i[2:0];
            panel_rst_q <= 1'b1;
            st_q        <= ST_ID_CMD;
          end
        end
        ST_ID_CMD: if (s_done) begin
          rd_cnt_q <= 2'd0;
          st_q     <= ST_ID_RD;
        end
        ST_ID_RD: if (s_done) begin
          rd_cnt_q <= rd_cnt_q + 2'd1;
          if (rd_cnt_q == 2'd0) id0_q <= scmd_rdata_i;
          if (rd_cnt_q == 2'd1) id1_q <= scmd_rdata_i;
          if (rd_cnt_q == 2'd2) begin
            if (panel_dec == 2'd0) begin
              err_q      <= ERR_PANEL;
              ctrl_pwr_q <= 1'b0;
              st_q       <= ST_OFF;
            end else begin
              panel_q     <= panel_dec;
              panel_rev_q <= id1_q;
              idx_q       <= PROG_UP;
              st_q        <= ST_PROG;
            end
          end
        end
        ST_PROG: begin
          case (step.op)
            OP_SEND:       if (s_done) idx_q <= idx_q + PROG_W'(1);
            OP_WAIT_WAKE,
            OP_WAIT_SLEEP: st_q <= ST_WAIT;
            default: begin
              if (idx_q < PROG_DN) begin
                active_q <= 1'b1;
                st_q     <= ST_ON;
              end else begin
                ctrl_pwr_q <= 1'b0;
                st_q       <= ST_OFF;
              end
            end
          endcase
        end
        ST_WAIT: if (t_done) begin
          idx_q <= idx_q + PROG_W'(1);
          st_q  <= ST_PROG;
        end
        ST_ON: if (pwr_dn_i) begin
          active_q <= 1'b0;
          idx_q    <= PROG_DN;
          st_q     <= ST_PROG;
        end
        default: st_q <= ST_OFF;
      endcase
    end
  end

  assign ctrl_pwr_o  = ctrl_pwr_q;
  assign panel_rst_o = panel_rst_q;
  assign active_o    = active_q;
  assign ver_o       = ver_q;
  assign step_o      = step_q;
  assign strap_o     = strap_q;
  assign panel_o     = panel_q;
  assign panel_rev_o = panel_rev_q;
  assign err_o       = err_q;
endmodule

// File: rtl/disp_bringup_seq_chk.sv
module disp_bringup_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pbus_req_o,
  input logic       scmd_req_o,
  input logic       ctrl_pwr_o,
  input logic       panel_rst_o,
  input logic       active_o,
  input logic [1:0] err_o
);
  assert_port_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pbus_req_o && scmd_req_o));

  assert_pbus_strobe_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pbus_req_o |=> !pbus_req_o);

  assert_scmd_strobe_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scmd_req_o |=> !scmd_req_o);

  assert_pbus_powered_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pbus_req_o |-> ctrl_pwr_o);

  assert_scmd_released_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scmd_req_o |-> panel_rst_o);

  assert_rst_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_rst_o |=> panel_rst_o);

  assert_active_lines_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (ctrl_pwr_o && panel_rst_o));

  assert_err_inactive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o != 2'd0) |-> !active_o);
endmodule

bind disp_bringup_seq disp_bringup_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pbus_req_o  (pbus_req_o),
  .scmd_req_o  (scmd_req_o),
  .ctrl_pwr_o  (ctrl_pwr_o),
  .panel_rst_o (panel_rst_o),
  .active_o    (active_o),
  .err_o       (err_o)
);

// File: tb/disp_bringup_seq_test.sv
module disp_bringup_seq_test;
  localparam int KHZ = 10;
  localparam int WAKE_CYC  = 120 * KHZ;
  localparam int SLEEP_CYC = 50 * KHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_up = 1'b0, pwr_dn = 1'b0;
  logic pbus_req, scmd_req, scmd_rd;
  logic [7:0] pbus_addr;
  logic [8:0] scmd_word;
  logic pbus_done = 1'b0, scmd_done = 1'b0;
  logic [7:0] pbus_rdata = 8'h00, scmd_rdata = 8'h00;
  logic ctrl_pwr, panel_rst, active;
  logic [1:0] ver, step, panel, err;
  logic [2:0] strap;
  logic [7:0] panel_rev;

  int checks = 0, errors = 0, cyc = 0;
  int exp_p[$], exp_s[$];
  logic [7:0] rev_val, cfg_val;
  logic [7:0] id_b [3];
  int id_ix;
  int p_cnt = 0, s_cnt = 0;
  logic [7:0] p_val, s_val;
  int s_last;
  int t_slp = -1, t_sin = -1, t_on = -1;
  int gap_wake = -1, gap_sleep = -1, gap_act = -1;
  logic pwr_prev = 1'b0, act_prev = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  disp_bringup_seq #(.CLK_KHZ(KHZ), .WAKE_MS(120), .SLEEP_MS(50)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_up_i(pwr_up), .pwr_dn_i(pwr_dn),
    .pbus_req_o(pbus_req), .pbus_addr_o(pbus_addr), .pbus_done_i(pbus_done),
    .pbus_rdata_i(pbus_rdata), .scmd_req_o(scmd_req), .scmd_rd_o(scmd_rd),
    .scmd_word_o(scmd_word), .scmd_done_i(scmd_done), .scmd_rdata_i(scmd_rdata),
    .ctrl_pwr_o(ctrl_pwr), .panel_rst_o(panel_rst), .active_o(active),
    .ver_o(ver), .step_o(step), .strap_o(strap), .panel_o(panel),
    .panel_rev_o(panel_rev), .err_o(err)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // parallel read engine model
  always @(negedge clk) begin
    if (rst_n) begin
      pbus_done = 1'b0;
      if (p_cnt > 0) begin
        p_cnt--;
        if (p_cnt == 0) begin pbus_done = 1'b1; pbus_rdata = p_val; end
      end
      if (pbus_req) begin
        if (exp_p.size() == 0) check(1'b0, "R11", "unexpected parallel read", pbus_addr, -1);
        else check(int'(pbus_addr) == exp_p.pop_front(), "R2", "parallel address", pbus_addr, -2);
        p_cnt = 2;
        p_val = (pbus_addr == 8'h00) ? rev_val : cfg_val;
      end
    end
  end

  // serial engine model; entry = 1024*rd + word
  always @(negedge clk) begin
    if (rst_n) begin
      scmd_done = 1'b0;
      if (s_cnt > 0) begin
        s_cnt--;
        if (s_cnt == 0) begin
          scmd_done = 1'b1; scmd_rdata = s_val;
          if (s_last == 'h011) t_slp = cyc;
          if (s_last == 'h010) t_sin = cyc;
          if (s_last == 'h029) t_on = cyc;
        end
      end
      if (scmd_req) begin
        s_last = scmd_rd ? 1024 + int'(scmd_word) : int'(scmd_word);
        if (exp_s.size() == 0) check(1'b0, "R11", "unexpected serial word", s_last, -1);
        else check(s_last == exp_s.pop_front(), "R7", "serial word", s_last, -2);
        if (s_last == 'h0C2) gap_wake = cyc - t_slp;
        if (s_last == 'h029) check(active == 1'b0, "R9", "active before display-on", active, 0);
        s_cnt = 2;
        s_val = 8'h00;
        if (scmd_rd) begin s_val = id_b[id_ix]; id_ix++; end
      end
      if (pwr_prev && !ctrl_pwr && t_sin >= 0) gap_sleep = cyc - t_sin;
      if (!act_prev && active && t_on >= 0) gap_act = cyc - t_on;
      pwr_prev = ctrl_pwr;
      act_prev = active;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up;
    @(negedge clk); pwr_up = 1'b1;
    @(negedge clk); pwr_up = 1'b0;
  endtask

  task automatic pulse_dn;
    @(negedge clk); pwr_dn = 1'b1;
    @(negedge clk); pwr_dn = 1'b0;
  endtask

  task automatic push_id;
    exp_p.push_back('h00); exp_p.push_back('h02);
    exp_s.push_back('h004);
    for (int i = 0; i < 3; i++) exp_s.push_back(1024);
  endtask

  task automatic push_wake;
    exp_s.push_back('h011); exp_s.push_back('h0C2); exp_s.push_back('h102);
    exp_s.push_back('h100); exp_s.push_back('h100); exp_s.push_back('h03A);
    exp_s.push_back('h170); exp_s.push_back('h029);
  endtask

  task automatic drained(input string rq);
    check(exp_p.size() == 0 && exp_s.size() == 0, rq, "pending transfers",
          exp_p.size() + exp_s.size(), 0);
  endtask

  initial begin
    run(3);
    rst_n = 1'b1;
    run(1);
    // R1 reset state
    check(!ctrl_pwr && !panel_rst && !active, "R1", "lines after reset",
          {ctrl_pwr, panel_rst, active}, 0);
    check(err == 2'd0 && !pbus_req && !scmd_req, "R1", "err/req after reset", err, 0);

    // R11 power-down while off
    pulse_dn; run(20);
    check(!ctrl_pwr && !active, "R11", "power-down while off", ctrl_pwr, 0);

    // R4 unknown controller
    rev_val = 8'h55; cfg_val = 8'h00; id_ix = 0;
    exp_p.push_back('h00); exp_p.push_back('h02);
    pulse_up;
    check(ctrl_pwr == 1'b1, "R2", "power line after request", ctrl_pwr, 1);
    run(20);
    check(err == 2'd1, "R4", "bad controller code", err, 1);
    check(!ctrl_pwr && !panel_rst && ver == 2'd0, "R4", "lines after bad controller",
          {ctrl_pwr, panel_rst}, 0);
    drained("R4");

    // R6 unknown panel, R12 error cleared on new request
    rev_val = 8'h9D; cfg_val = 8'hFD; id_b = '{8'h12, 8'h34, 8'h56}; id_ix = 0;
    push_id;
    pulse_up;
    check(err == 2'd0, "R12", "error cleared by accepted request", err, 0);
    run(40);
    check(err == 2'd2, "R6", "bad panel code", err, 2);
    check(!ctrl_pwr && panel_rst, "R6", "lines after bad panel", {ctrl_pwr, panel_rst}, 1);
    check(ver == 2'd2 && step == 2'd1 && strap == 3'd5, "R3", "version/step/strap 9D",
          {ver, step, strap}, {2'd2, 2'd1, 3'd5});
    check(panel == 2'd0, "R6", "no panel type", panel, 0);
    drained("R6");

    // R5 R7 R8 R9 good bring-up
    rev_val = 8'hA6; cfg_val = 8'h03; id_b = '{8'h83, 8'h5A, 8'h01}; id_ix = 0;
    push_id; push_wake;
    pulse_up; run(1400);
    check(active == 1'b1 && ctrl_pwr && err == 2'd0, "R9", "active after wake", active, 1);
    check(ver == 2'd1 && step == 2'd2 && strap == 3'd3, "R3", "version/step/strap A6",
          {ver, step, strap}, {2'd1, 2'd2, 3'd3});
    check(panel == 2'd2 && panel_rev == 8'h5A, "R5", "panel type/rev",
          {panel, panel_rev}, {2'd2, 8'h5A});
    check(gap_wake >= WAKE_CYC && gap_wake <= WAKE_CYC + 6, "R8", "wake wait cycles",
          gap_wake, WAKE_CYC);
    check(gap_act >= 1 && gap_act <= 3, "R9", "active delay", gap_act, 2);
    drained("R7");

    // R11 power-up while active
    pulse_up; run(50);
    check(active && ctrl_pwr, "R11", "power-up while active", active, 1);
    drained("R11");

    // R10 power-down
    exp_s.push_back('h028); exp_s.push_back('h010);
    pulse_dn;
    check(active == 1'b0, "R10", "active cleared on power-down", active, 0);
    run(700);
    check(!ctrl_pwr && panel_rst && !active, "R10", "lines after power-down",
          {ctrl_pwr, panel_rst, active}, 2);
    check(gap_sleep >= SLEEP_CYC && gap_sleep <= SLEEP_CYC + 6, "R10", "sleep wait cycles",
          gap_sleep, SLEEP_CYC);
    drained("R10");

    // R11 requests during a running sequence, R3 R5 other codes
    rev_val = 8'h9C; cfg_val = 8'h00; id_b = '{8'h45, 8'h07, 8'h00}; id_ix = 0;
    push_id; push_wake;
    pulse_up; run(15);
    pulse_dn; run(100);
    pulse_up; pulse_dn; run(1300);
    check(active == 1'b1, "R11", "requests ignored while busy", active, 1);
    check(ver == 2'd2 && step == 2'd0, "R3", "version/step 9C", {ver, step}, {2'd2, 2'd0});
    check(panel == 2'd1 && panel_rev == 8'h07, "R5", "panel type/rev 45",
          {panel, panel_rev}, {2'd1, 8'h07});
    drained("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule